// File: doc/BRIEF.md
# Randomized Root Contention Resolver

When two neighbouring nodes each try to make the other its parent, neither can finish the tree setup until one of them gives way. This block is the per-node controller that breaks such a tie. It backs off by sending an idle symbol and draws a random fast-or-slow choice. It then waits for a number of ticks inside the window belonging to that choice. When the wait ends, it either acknowledges a peer that is still requesting, which makes it the root, or it sends a fresh request. A fresh request ends with the node as child if the peer acknowledges, or sends it back into contention if the peer also requested again.

All symbol interfaces are single-cycle strobes with no back-pressure: a received strobe is consumed in the cycle it is high, and a send strobe is a one-cycle pulse that the link logic must take at once. The tick input advances the wait timer by one per high cycle. The random bit is provided by an external source. All outputs are registered, so a decision taken in one cycle shows on the pins in the next.

Top module: `contention_resolver`

## Requirements
- R1: While rst_n is low, all five outputs are low and the node is in contention. On the first clock edge after release, with rx_idle low, it sends idle, so tx_idle is high in the first cycle after reset.
- R2: coin_fast is sampled only at the edge where the node sends idle: 1 selects the fast window (76..85 ticks) and 0 selects the slow window (159..167 ticks). Changing coin_fast during a wait has no effect on the outcome.
- R3: Sending idle clears the wait timer, and each cycle with tick high adds one. The node acts in the cycle after the timer first equals the window minimum. With tick high every cycle and no received symbol, the action strobe therefore appears 77 cycles after tx_idle for fast and 160 cycles after for slow, and never earlier.
- R4: With tick held low, a waiting node never acts.
- R5: A node waiting after idle from contention, with no received symbol, ends its wait with one tx_ack pulse, and is_root rises in the same cycle.
- R6: rx_idle in contention moves the node to a peer-idle state with no send in that cycle. From there it sends idle and waits. At the end of the wait it sends one tx_req pulse instead of an acknowledge. rx_req in the peer-idle state returns the node to contention.
- R7: While waiting, rx_idle (when the peer was requesting) or rx_req (when the peer was idle) switches the wait kind but keeps the timer value and the speed. A switch before the minimum therefore does not change when the node acts, only which symbol it sends.
- R8: When the timer equals the window maximum, the node takes its pending action in that cycle even if a switching symbol is received. With rx_idle and rx_req both held high from the idle send, a fast node sends tx_req 86 cycles after tx_idle.
- R9: After tx_req, rx_ack makes the node child (is_child high next cycle). rx_req returns it to contention, and it sends idle again on the following edge. If both arrive in the same cycle, rx_req wins.
- R10: Root and child are terminal until reset. They are never high together, and once either is set, no send strobe occurs and received symbols and ticks have no effect.
- R11: At most one of tx_req, tx_ack, tx_idle is high in any cycle, and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_req | input | 1 | Request received from peer (strobe) |
| rx_ack | input | 1 | Acknowledge received from peer (strobe) |
| rx_idle | input | 1 | Idle received from peer (strobe) |
| tick | input | 1 | Timer advance enable |
| coin_fast | input | 1 | Random bit, 1 = fast window |
| tx_req | output | 1 | Send request (pulse) |
| tx_ack | output | 1 | Send acknowledge (pulse) |
| tx_idle | output | 1 | Send idle (pulse) |
| is_root | output | 1 | Node resolved as root |
| is_child | output | 1 | Node resolved as child |

## Verification
The wait is run with each coin value and with the coin toggled mid-wait. Matching the 77 and 160 cycle latencies separates the two windows and shows that the draw happens only once. A lone mid-wait rx_idle must keep the 77-cycle latency but turn the acknowledge into a request, which shows that the timer survives a switch. Holding both switching symbols high keeps the node flipping between wait kinds until the maximum, so only a design that enforces the deadline acts at exactly 86 cycles. The request-sent tests apply rx_ack alone, rx_req alone and both together to separate child, re-contention and their priority.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic [3:0] {
    ST_CONTEND     = 4'd0,
    ST_PEER_IDLE   = 4'd1,
    ST_WREQ_FAST   = 4'd2,
    ST_WREQ_SLOW   = 4'd3,
    ST_WIDLE_FAST  = 4'd4,
    ST_WIDLE_SLOW  = 4'd5,
    ST_REQ_SENT    = 4'd6,
    ST_ROOT        = 4'd7,
    ST_CHILD       = 4'd8
  } cr_state_e;
endpackage

// File: rtl/cr_timer.sv
module cr_timer #(
  parameter int SAT = 168,
  localparam int TW = $clog2(SAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  output logic [TW-1:0] value
);
  localparam logic [TW-1:0] SAT_W = TW'(SAT);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      value <= '0;
    else if (tick && value < SAT_W)
      value <= value + 1'b1;
  end
endmodule

// File: rtl/cr_window.sv
module cr_window #(
  parameter int FAST_MIN = 76,
  parameter int FAST_MAX = 85,
  parameter int SLOW_MIN = 159,
  parameter int SLOW_MAX = 167,
  parameter int TW       = 8
) (
  input  logic [TW-1:0] tmr,
  input  logic          sel_fast,
  output logic          at_min,
  output logic          at_max
);
  localparam logic [TW-1:0] FMIN = TW'(FAST_MIN);
  localparam logic [TW-1:0] FMAX = TW'(FAST_MAX);
  localparam logic [TW-1:0] SMIN = TW'(SLOW_MIN);
  localparam logic [TW-1:0] SMAX = TW'(SLOW_MAX);

  always_comb begin
    at_min = sel_fast ? (tmr >= FMIN) : (tmr >= SMIN);
    at_max = sel_fast ? (tmr >= FMAX) : (tmr >= SMAX);
  end
endmodule

// File: rtl/cr_fsm.sv
module cr_fsm
  import cr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rx_req,
  input  logic      rx_ack,
  input  logic      rx_idle,
  input  logic      coin_fast,
  input  logic      at_min,
  input  logic      at_max,
  output cr_state_e st,
  output logic      sel_fast,
  output logic      waiting,
  output logic      tmr_clr,
  output logic      tx_req,
  output logic      tx_ack,
  output logic      tx_idle
);
  cr_state_e st_n;
  logic      snd_req, snd_ack, snd_idle;

  always_comb begin
    sel_fast = (st == ST_WREQ_FAST) || (st == ST_WIDLE_FAST);
    waiting  = (st == ST_WREQ_FAST) || (st == ST_WREQ_SLOW) ||
               (st == ST_WIDLE_FAST) || (st == ST_WIDLE_SLOW);
  end

  always_comb begin
    st_n     = st;
    snd_req  = 1'b0;
    snd_ack  = 1'b0;
    snd_idle = 1'b0;
    tmr_clr  = 1'b0;
    unique case (st)
      ST_CONTEND: begin
        if (rx_idle) begin
          st_n = ST_PEER_IDLE;
        end else begin
          st_n     = coin_fast ? ST_WREQ_FAST : ST_WREQ_SLOW;
          snd_idle = 1'b1;
          tmr_clr  = 1'b1;
        end
      end
      ST_PEER_IDLE: begin
        if (rx_req) begin
          st_n = ST_CONTEND;
        end else begin
          st_n     = coin_fast ? ST_WIDLE_FAST : ST_WIDLE_SLOW;
          snd_idle = 1'b1;
          tmr_clr  = 1'b1;
        end
      end
      ST_WREQ_FAST, ST_WREQ_SLOW: begin
        if (at_max || (!rx_idle && at_min)) begin
          st_n    = ST_ROOT;
          snd_ack = 1'b1;
          tmr_clr = 1'b1;
        end else if (rx_idle) begin
          st_n = sel_fast ? ST_WIDLE_FAST : ST_WIDLE_SLOW;
        end
      end
      ST_WIDLE_FAST, ST_WIDLE_SLOW: begin
        if (at_max || (!rx_req && at_min)) begin
          st_n    = ST_REQ_SENT;
          snd_req = 1'b1;
          tmr_clr = 1'b1;
        end else if (rx_req) begin
          st_n = sel_fast ? ST_WREQ_FAST : ST_WREQ_SLOW;
        end
      end
      ST_REQ_SENT: begin
        if (rx_req)
          st_n = ST_CONTEND;
        else if (rx_ack)
          st_n = ST_CHILD;
      end
      ST_ROOT, ST_CHILD: st_n = st;
      default: st_n = ST_CONTEND;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_CONTEND;
      tx_req  <= 1'b0;
      tx_ack  <= 1'b0;
      tx_idle <= 1'b0;
    end else begin
      st      <= st_n;
      tx_req  <= snd_req;
      tx_ack  <= snd_ack;
      tx_idle <= snd_idle;
    end
  end
endmodule

// File: rtl/contention_resolver.sv
module contention_resolver
  import cr_pkg::*;
#(
  parameter int FAST_MIN = 76,
  parameter int FAST_MAX = 85,
  parameter int SLOW_MIN = 159,
  parameter int SLOW_MAX = 167,
  localparam int SAT = SLOW_MAX + 1,
  localparam int TW  = $clog2(SAT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_req,
  input  logic rx_ack,
  input  logic rx_idle,
  input  logic tick,
  input  logic coin_fast,
  output logic tx_req,
  output logic tx_ack,
  output logic tx_idle,
  output logic is_root,
  output logic is_child
);
  cr_state_e      st;
  logic [TW-1:0]  tmr;
  logic           tmr_clr, sel_fast, waiting, at_min, at_max;

  cr_timer #(.SAT(SAT)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .tick(tick), .value(tmr)
  );

  cr_window #(
    .FAST_MIN(FAST_MIN), .FAST_MAX(FAST_MAX),
    .SLOW_MIN(SLOW_MIN), .SLOW_MAX(SLOW_MAX), .TW(TW)
  ) u_window (
    .tmr(tmr), .sel_fast(sel_fast), .at_min(at_min), .at_max(at_max)
  );

  cr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .rx_req(rx_req), .rx_ack(rx_ack), .rx_idle(rx_idle),
    .coin_fast(coin_fast), .at_min(at_min), .at_max(at_max),
    .st(st), .sel_fast(sel_fast), .waiting(waiting), .tmr_clr(tmr_clr),
    .tx_req(tx_req), .tx_ack(tx_ack), .tx_idle(tx_idle)
  );

  assign is_root  = (st == ST_ROOT);
  assign is_child = (st == ST_CHILD);
endmodule

// File: rtl/cr_checker.sv
module cr_checker #(
  parameter int FAST_MIN = 76,
  parameter int FAST_MAX = 85,
  parameter int SLOW_MAX = 167,
  parameter int TW       = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_req,
  input logic          tx_ack,
  input logic          tx_idle,
  input logic          is_root,
  input logic          is_child,
  input logic          waiting,
  input logic          sel_fast,
  input logic [TW-1:0] tmr
);
  localparam logic [TW-1:0] FMIN = TW'(FAST_MIN);
  localparam logic [TW-1:0] FMAX = TW'(FAST_MAX);
  localparam logic [TW-1:0] SMAX = TW'(SLOW_MAX);

  AST_ONE_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_req, tx_ack, tx_idle})); // R11
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |=> !tx_ack); // R11
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> !tx_req); // R11
  AST_ROLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_root && is_child)); // R10
  AST_ROOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    is_root |=> is_root && !tx_req && !tx_idle); // R10
  AST_CHILD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    is_child |=> is_child && !tx_req && !tx_ack && !tx_idle); // R10
  AST_ACK_MAKES_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |-> is_root); // R5
  AST_WAIT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (tmr <= (sel_fast ? FMAX : SMAX))); // R8
  AST_NO_EARLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |-> $past(tmr) >= FMIN); // R3
endmodule

bind contention_resolver cr_checker #(
  .FAST_MIN(FAST_MIN), .FAST_MAX(FAST_MAX), .SLOW_MAX(SLOW_MAX), .TW(TW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_ack(tx_ack),
  .tx_idle(tx_idle), .is_root(is_root), .is_child(is_child),
  .waiting(waiting), .sel_fast(sel_fast), .tmr(tmr)
);

// File: tb/contention_resolver_test.sv
module contention_resolver_test;
  logic clk = 1'b0;
  logic rst_n, rx_req, rx_ack, rx_idle, tick, coin_fast;
  logic tx_req, tx_ack, tx_idle, is_root, is_child;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  localparam int FAST_LAT = 77;
  localparam int SLOW_LAT = 160;
  localparam int DEADLINE_LAT = 86;

  always #5 clk = ~clk;

  contention_resolver uut (
    .clk(clk), .rst_n(rst_n), .rx_req(rx_req), .rx_ack(rx_ack),
    .rx_idle(rx_idle), .tick(tick), .coin_fast(coin_fast),
    .tx_req(tx_req), .tx_ack(tx_ack), .tx_idle(tx_idle),
    .is_root(is_root), .is_child(is_child)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply_reset(input bit pre_idle, input bit coin);
    @(negedge clk);
    rst_n = 1'b0; rx_req = 1'b0; rx_ack = 1'b0; rx_idle = pre_idle;
    tick = 1'b1; coin_fast = coin;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    if (pre_idle) begin
      @(negedge clk);
      rx_idle = 1'b0;
    end
  endtask

  task automatic wait_idle(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 8 && !seen; i++) begin
      @(negedge clk);
      if (tx_idle) seen = 1'b1;
    end
  endtask

  task automatic wait_act(output int n, output bit got_ack, output bit got_req);
    n = 0; got_ack = 1'b0; got_req = 1'b0;
    while (n < 400 && !got_ack && !got_req) begin
      @(negedge clk);
      n++;
      got_ack = tx_ack;
      got_req = tx_req;
    end
  endtask

  task automatic t_reset;
    bit seen;
    @(negedge clk);
    rst_n = 1'b0; rx_req = 1'b0; rx_ack = 1'b0; rx_idle = 1'b0;
    tick = 1'b1; coin_fast = 1'b1;
    repeat (3) @(negedge clk);
    check({tx_req, tx_ack, tx_idle, is_root, is_child} == 5'b0, "R1",
          "outputs in reset", {tx_req, tx_ack, tx_idle, is_root, is_child}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    seen = tx_idle;
    check(seen, "R1", "idle sent first cycle after reset", seen, 1);
  endtask

  task automatic t_fast_root;
    bit seen, a, r; int n;
    apply_reset(1'b0, 1'b1);
    wait_idle(seen);
    wait_act(n, a, r);
    check(a && !r && n == FAST_LAT, "R3", "fast ack latency", n, FAST_LAT);
    check(is_root && !is_child, "R5", "root with ack", is_root, 1);
  endtask

  task automatic t_slow_coin_ignored;
    bit seen, a, r; int n;
    apply_reset(1'b0, 1'b0);
    wait_idle(seen);
    coin_fast = 1'b1;
    wait_act(n, a, r);
    check(a && n == SLOW_LAT, "R2", "slow latency coin=0", n, SLOW_LAT);
    apply_reset(1'b0, 1'b1);
    wait_idle(seen);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      coin_fast = ~coin_fast;
    end
    wait_act(n, a, r);
    check(a && n + 40 == FAST_LAT, "R2", "coin toggled during wait", n + 40, FAST_LAT);
  endtask

  task automatic t_no_tick;
    bit seen, a, r; int n; int hits = 0;
    apply_reset(1'b0, 1'b1);
    wait_idle(seen);
    tick = 1'b0;
    for (int i = 0; i < 250; i++) begin
      @(negedge clk);
      if (tx_ack || tx_req || is_root) hits++;
    end
    check(hits == 0, "R4", "action without ticks", hits, 0);
    tick = 1'b1;
    wait_act(n, a, r);
    check(a && n == FAST_LAT, "R4", "acts once ticks resume", n, FAST_LAT);
  endtask

  task automatic t_peer_idle_child;
    bit seen, a, r; int n;
    apply_reset(1'b1, 1'b1);
    check(!tx_idle, "R6", "no send on rx_idle in contention", tx_idle, 0);
    wait_idle(seen);
    check(seen, "R6", "idle sent from peer-idle state", seen, 1);
    wait_act(n, a, r);
    check(r && !a && n == FAST_LAT, "R6", "request after peer idle", n, FAST_LAT);
    rx_ack = 1'b1;
    @(negedge clk);
    rx_ack = 1'b0;
    check(is_child && !is_root, "R9", "child after rx_ack", is_child, 1);
  endtask

  task automatic t_switch_keeps_timer;
    bit seen, a, r; int n;
    apply_reset(1'b0, 1'b1);
    wait_idle(seen);
    repeat (10) @(negedge clk);
    rx_idle = 1'b1;
    @(negedge clk);
    rx_idle = 1'b0;
    wait_act(n, a, r);
    check(r && !a && n + 11 == FAST_LAT, "R7", "switch keeps timer", n + 11, FAST_LAT);
  endtask

  task automatic t_deadline;
    bit seen, a, r; int n;
    apply_reset(1'b0, 1'b1);
    wait_idle(seen);
    rx_idle = 1'b1; rx_req = 1'b1;
    wait_act(n, a, r);
    rx_idle = 1'b0; rx_req = 1'b0;
    check(r && !a && n == DEADLINE_LAT, "R8", "forced action at max", n, DEADLINE_LAT);
  endtask

  task automatic t_recontend(input bit with_ack);
    bit seen, a, r; int n;
    apply_reset(1'b1, 1'b1);
    wait_idle(seen);
    wait_act(n, a, r);
    coin_fast = 1'b0;
    rx_req = 1'b1; rx_ack = with_ack;
    @(negedge clk);
    rx_req = 1'b0; rx_ack = 1'b0;
    check(!tx_idle && !is_child, "R9", "back in contention", is_child, 0);
    @(negedge clk);
    check(tx_idle, "R9", "idle resent after rx_req", tx_idle, 1);
    wait_act(n, a, r);
    check(a && n == SLOW_LAT, "R9", "new slow draw after re-contention", n, SLOW_LAT);
  endtask

  task automatic t_terminal;
    bit seen, a, r; int n; int bad = 0;
    apply_reset(1'b0, 1'b1);
    wait_idle(seen);
    wait_act(n, a, r);
    for (int i = 0; i < 300; i++) begin
      rx_req = (i % 3 == 0); rx_ack = (i % 3 == 1); rx_idle = (i % 3 == 2);
      @(negedge clk);
      if (!is_root || is_child || tx_req || tx_ack || tx_idle) bad++;
    end
    rx_req = 1'b0; rx_ack = 1'b0; rx_idle = 1'b0;
    check(bad == 0, "R10", "root terminal under stimulus", bad, 0);
  endtask

  initial begin
    rst_n = 1'b0; rx_req = 1'b0; rx_ack = 1'b0; rx_idle = 1'b0;
    tick = 1'b0; coin_fast = 1'b0;
    t_reset();
    t_fast_root();
    t_slow_coin_ignored();
    t_no_tick();
    t_peer_idle_child();
    t_switch_keeps_timer();
    t_deadline();
    t_recontend(1'b0);
    t_recontend(1'b1);
    t_terminal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule